// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Controller

This block gathers fourteen general-purpose interrupt request lines into a pending-flag register. A rising edge on a line marks that line as pending. Each pending line is qualified by one of two enable sources. In normal operation the source is a per-line enable register together with a global mask bit. While the processor is halted for debug, a separate per-line debug enable register is used and the global mask plays no part. From the qualified set, a fixed-priority picker selects the lowest-numbered line.

The block raises a take-interrupt request toward the sequencer only when the sequencer signals that it is sitting between two instructions. When the sequencer acknowledges the request, three things happen. The pending flag of the chosen line is cleared. The current instruction counter is captured as the return address. The global mask is set, so no further maskable interrupt nests until software clears the mask again.

Software reaches the enable registers and the mask through a small select/write/read port. The pending flags can be read through the same port but cannot be written.

Top module: `mirq_ctl`

## Requirements
- R1: After a synchronous reset, the pending flags, the enable register and the debug enable register are all zero, the global mask is 1, take_req is 0 and ret_addr is 0.
- R2: A 0-to-1 transition on irq_lines bit k-1 sets the pending flag of line k at that clock edge. A line held high sets its flag only once. The flags read back as cfg_rdata with cfg_sel = 3, where bit k-1 is line k.
- R3: An acknowledge clears only the pending flag of the line reported in take_id. If a new rising edge on that same line arrives in the acknowledge cycle, the flag stays set.
- R4: With dbg_halt = 0, a pending line is qualified only when its enable bit is 1 and the global mask is 0.
- R5: With dbg_halt = 1, a pending line is qualified when its debug enable bit is 1, whatever the global mask and the enable register hold.
- R6: When several lines are qualified, take_id reports the lowest-numbered one, coded as its line number 1 to 14.
- R7: take_req is registered. It is 1 in the cycle after a cycle in which at_boundary was 1 and at least one line was qualified, and it stays 0 while at_boundary is 0.
- R8: An acknowledge (take_ack = 1 while take_req = 1) makes the global mask 1 and ret_addr equal to the pc_count of the acknowledge cycle at the next edge, and take_req is 0 in the following cycle.
- R9: A write with cfg_we = 1 loads the enable register when cfg_sel = 0, the debug enable register when cfg_sel = 1, and the global mask from cfg_wdata bit 0 when cfg_sel = 2. cfg_rdata shows the selected register one cycle after cfg_sel is applied, with the mask in bit 0 and zeros above. A write with cfg_sel = 3 has no effect.
- R10: take_ack while take_req is 0 changes no flag, no mask and no return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_LINES | Request lines; bit k-1 is line k |
| dbg_halt | input | 1 | Debug-halt mode: selects the debug enable register |
| at_boundary | input | 1 | Sequencer is between two instructions |
| pc_count | input | ADDR_W | Current instruction counter |
| take_ack | input | 1 | Sequencer accepts the pending take request |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 enable, 1 debug enable, 2 global mask, 3 flags (read only) |
| cfg_wdata | input | N_LINES | Register write data |
| cfg_rdata | output | N_LINES | Registered read data of the selected register |
| take_req | output | 1 | Take-interrupt request |
| take_id | output | ID_W | Line number of the requested interrupt (1 to N_LINES) |
| ret_addr | output | ADDR_W | Return address captured on acknowledge |
| gmask | output | 1 | Global mask bit (1 blocks maskable interrupts in normal mode) |

## Verification
The bench builds the block with its full fourteen lines and a 16-bit instruction counter. At that size every line can be swept one at a time, and every one of the 91 unordered pairs of lines can be raised together. This checks priority across the whole line set rather than a sample of it. The 16-bit counter keeps captured return addresses distinct and easy to compare. Mode changes, boundary gating, the same-cycle edge-and-clear race and stray acknowledges are each driven as short directed sequences on top of the sweeps.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  typedef enum logic [1:0] {
    CFG_EN   = 2'd0,
    CFG_DBG  = 2'd1,
    CFG_MASK = 2'd2,
    CFG_FLAG = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/mirq_flags.sv
module mirq_flags #(
  parameter int N_LINES = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] clr,
  output logic [N_LINES-1:0] flags
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_bit
    logic prev_q;
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= lines[g];
        // a fresh edge wins over a clear in the same cycle
        flag_q <= (flag_q & ~clr[g]) | (lines[g] & ~prev_q);
      end
    end
    assign flags[g] = flag_q;
  end
endmodule

// File: rtl/mirq_regs.sv
module mirq_regs
  import mirq_pkg::*;
#(
  parameter int N_LINES = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [N_LINES-1:0] wdata,
  input  logic               set_mask,
  input  logic [N_LINES-1:0] flags,
  output logic [N_LINES-1:0] en,
  output logic [N_LINES-1:0] dbg_en,
  output logic               gmask,
  output logic [N_LINES-1:0] rdata
);
  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= '0;
      dbg_en <= '0;
      gmask  <= 1'b1;
      rdata  <= '0;
    end else begin
      if (we && sel_e == CFG_EN)  en     <= wdata;
      if (we && sel_e == CFG_DBG) dbg_en <= wdata;
      if (set_mask)                        gmask <= 1'b1;
      else if (we && sel_e == CFG_MASK)    gmask <= wdata[0];
      case (sel_e)
        CFG_EN:   rdata <= en;
        CFG_DBG:  rdata <= dbg_en;
        CFG_MASK: rdata <= {{(N_LINES-1){1'b0}}, gmask};
        default:  rdata <= flags;
      endcase
    end
  end
endmodule

// File: rtl/mirq_pick.sv
module mirq_pick #(
  parameter int N_LINES = 14,
  parameter int ID_W    = 4
) (
  input  logic [N_LINES-1:0] req,
  output logic               any,
  output logic [ID_W-1:0]    id,
  output logic [N_LINES-1:0] onehot
);
  always_comb begin
    any    = |req;
    id     = '0;
    onehot = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        id        = ID_W'(i + 1);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mirq_ctl.sv
module mirq_ctl #(
  parameter int N_LINES = 14,
  parameter int ADDR_W  = 16,
  localparam int ID_W   = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               dbg_halt,
  input  logic               at_boundary,
  input  logic [ADDR_W-1:0]  pc_count,
  input  logic               take_ack,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [N_LINES-1:0] cfg_wdata,
  output logic [N_LINES-1:0] cfg_rdata,
  output logic               take_req,
  output logic [ID_W-1:0]    take_id,
  output logic [ADDR_W-1:0]  ret_addr,
  output logic               gmask
);
  logic [N_LINES-1:0] flags, en, dbg_en, qual, pick_oh, take_oh, clr_vec;
  logic               pick_any, ack_fire;
  logic [ID_W-1:0]    pick_id;

  assign ack_fire = take_req & take_ack;
  assign clr_vec  = ack_fire ? take_oh : '0;

  mirq_flags #(.N_LINES(N_LINES)) u_flags (
    .clk(clk), .rst(rst), .lines(irq_lines), .clr(clr_vec), .flags(flags)
  );

  mirq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .set_mask(ack_fire), .flags(flags), .en(en), .dbg_en(dbg_en),
    .gmask(gmask), .rdata(cfg_rdata)
  );

  // debug halt swaps in its own enable set and bypasses the global mask
  assign qual = flags & (dbg_halt ? dbg_en : (gmask ? '0 : en));

  mirq_pick #(.N_LINES(N_LINES), .ID_W(ID_W)) u_pick (
    .req(qual), .any(pick_any), .id(pick_id), .onehot(pick_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_req <= 1'b0;
      take_id  <= '0;
      take_oh  <= '0;
      ret_addr <= '0;
    end else begin
      take_req <= at_boundary & ~ack_fire & pick_any;
      take_id  <= pick_id;
      take_oh  <= pick_oh;
      if (ack_fire) ret_addr <= pc_count;
    end
  end
endmodule

// File: rtl/mirq_ctl_chk.sv
module mirq_ctl_chk #(
  parameter int N_LINES = 14,
  parameter int ADDR_W  = 16,
  parameter int ID_W    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               at_boundary,
  input logic               take_ack,
  input logic [ADDR_W-1:0]  pc_count,
  input logic               take_req,
  input logic [ID_W-1:0]    take_id,
  input logic [ADDR_W-1:0]  ret_addr,
  input logic               gmask,
  input logic [N_LINES-1:0] clr_vec
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!take_req && gmask && ret_addr == '0));

  p_single_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_vec));

  p_id_range_r6: assert property (@(posedge clk) disable iff (rst)
    take_req |-> (take_id >= ID_W'(1) && take_id <= ID_W'(N_LINES)));

  p_req_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    take_req |-> $past(at_boundary));

  p_ack_masks_r8: assert property (@(posedge clk) disable iff (rst)
    (take_req && take_ack) |=> gmask);

  p_ack_return_r8: assert property (@(posedge clk) disable iff (rst)
    (take_req && take_ack) |=> (ret_addr == $past(pc_count)));

  p_ack_drops_req_r8: assert property (@(posedge clk) disable iff (rst)
    (take_req && take_ack) |=> !take_req);

  p_stray_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (take_ack && !take_req) |=> $stable(ret_addr));
endmodule

bind mirq_ctl mirq_ctl_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .at_boundary(at_boundary), .take_ack(take_ack),
  .pc_count(pc_count), .take_req(take_req), .take_id(take_id),
  .ret_addr(ret_addr), .gmask(gmask), .clr_vec(clr_vec)
);

// File: tb/test_mirq_ctl.sv
`timescale 1ns/1ps
module test_mirq_ctl;
  localparam int N  = 14;
  localparam int AW = 16;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] irq_lines = '0, cfg_wdata = '0, cfg_rdata;
  logic dbg_halt = 1'b0, at_boundary = 1'b1, take_ack = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] pc_count = '0, ret_addr;
  logic [1:0] cfg_sel = 2'd0;
  logic take_req, gmask;
  logic [IW-1:0] take_id;
  int n_cmp = 0, n_bad = 0;
  logic [N-1:0] rv;
  logic [AW-1:0] saved;

  always #2 clk = ~clk;

  mirq_ctl #(.N_LINES(N), .ADDR_W(AW)) i_mirq_ctl (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .dbg_halt(dbg_halt),
    .at_boundary(at_boundary), .pc_count(pc_count), .take_ack(take_ack),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .take_req(take_req), .take_id(take_id),
    .ret_addr(ret_addr), .gmask(gmask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [N-1:0] v);
    @(negedge clk); cfg_sel = s;
    @(negedge clk); v = cfg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); irq_lines = m;
    @(negedge clk); irq_lines = '0;
  endtask

  // call at a negedge where take_req is 1
  task automatic ack(input string tag, input logic [AW-1:0] pc);
    take_ack = 1'b1; pc_count = pc;
    @(negedge clk); take_ack = 1'b0;
    chk({tag, " R8 mask"}, gmask, 1);
    chk({tag, " R8 ret_addr"}, ret_addr, pc);
    chk({tag, " R8 req drop"}, take_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 take_req", take_req, 0);
    chk("R1 gmask", gmask, 1);
    chk("R1 ret_addr", ret_addr, 0);
    rd(2'd0, rv); chk("R1 en", rv, 0);
    rd(2'd1, rv); chk("R1 dbg_en", rv, 0);
    rd(2'd3, rv); chk("R1 flags", rv, 0);

    // R9 register access
    wr(2'd0, 14'h1555); rd(2'd0, rv); chk("R9 en", rv, 14'h1555);
    wr(2'd1, 14'h2AAA); rd(2'd1, rv); chk("R9 dbg_en", rv, 14'h2AAA);
    wr(2'd2, 14'h3FFF); rd(2'd2, rv); chk("R9 mask set", rv, 1);
    wr(2'd2, 14'h3FFE); rd(2'd2, rv); chk("R9 mask clr", rv, 0);
    wr(2'd3, 14'h3FFF); rd(2'd3, rv); chk("R9 flags write ignored", rv, 0);
    chk("R9 no req", take_req, 0);

    // single-line sweep: R2 R4 R6 R7 R8
    wr(2'd0, '1);
    for (int k = 1; k <= N; k++) begin
      wr(2'd2, '0);
      pulse(N'(1) << (k - 1));
      chk("R7 latency", take_req, 0);
      @(negedge clk);
      chk("R2 req", take_req, 1);
      chk("R6 id single", take_id, k);
      ack("sweep", AW'(16'h1000 + k * 3));
      rd(2'd3, rv); chk("R3 flag cleared", rv, 0);
    end

    // pair sweep: R6 priority
    for (int a = 1; a <= N; a++) begin
      for (int b = a + 1; b <= N; b++) begin
        pulse((N'(1) << (a - 1)) | (N'(1) << (b - 1)));
        rd(2'd3, rv); chk("R2 both flags", rv, (N'(1) << (a - 1)) | (N'(1) << (b - 1)));
        wr(2'd2, '0);
        @(negedge clk);
        chk("R6 first", take_id, a);
        ack("pair a", AW'(a));
        wr(2'd2, '0);
        @(negedge clk);
        chk("R6 second", take_id, b);
        ack("pair b", AW'(b));
      end
    end

    // R4 enable and mask gating
    wr(2'd0, ~(N'(1) << 3));
    wr(2'd2, '0);
    pulse(N'(1) << 3);
    @(negedge clk); chk("R4 disabled", take_req, 0);
    @(negedge clk); chk("R4 disabled", take_req, 0);
    wr(2'd2, 14'h1);
    wr(2'd0, '1);
    @(negedge clk); chk("R4 masked", take_req, 0);
    wr(2'd2, '0);
    @(negedge clk); chk("R4 released", take_req, 1); chk("R4 id", take_id, 4);
    ack("R4", 16'hA004);

    // R5 debug halt: gmask is 1 here
    wr(2'd0, '0);
    wr(2'd1, N'(1) << 4);
    dbg_halt = 1'b1;
    pulse(N'(1) << 4);
    @(negedge clk); chk("R5 dbg req", take_req, 1); chk("R5 dbg id", take_id, 5);
    ack("R5", 16'hD005);
    wr(2'd1, '0);
    wr(2'd0, '1);
    wr(2'd2, '0);
    pulse(N'(1) << 5);
    @(negedge clk); chk("R5 dbg disabled", take_req, 0);
    @(negedge clk); chk("R5 dbg disabled", take_req, 0);
    dbg_halt = 1'b0;
    @(negedge clk); chk("R5 back to normal", take_req, 1); chk("R5 id", take_id, 6);
    ack("R5 normal", 16'h0006);

    // R7 boundary gating
    at_boundary = 1'b0;
    wr(2'd2, '0);
    pulse(N'(1) << 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R7 no boundary", take_req, 0);
    end
    at_boundary = 1'b1;
    @(negedge clk); chk("R7 boundary", take_req, 1); chk("R7 id", take_id, 3);
    ack("R7", 16'h7003);

    // R3 new edge in the acknowledge cycle keeps the flag
    wr(2'd2, '0);
    pulse(N'(1) << 6);
    @(negedge clk); chk("R3 req", take_req, 1);
    irq_lines = N'(1) << 6;
    ack("R3", 16'h3007);
    irq_lines = '0;
    rd(2'd3, rv); chk("R3 flag kept", rv, N'(1) << 6);
    wr(2'd2, '0);
    @(negedge clk); chk("R3 again", take_id, 7);
    ack("R3 again", 16'h3008);
    rd(2'd3, rv); chk("R3 flag gone", rv, 0);

    // R2 held line sets once
    @(negedge clk); irq_lines = N'(1) << 1;
    wr(2'd2, '0);
    @(negedge clk); chk("R2 held req", take_req, 1); chk("R2 id", take_id, 2);
    ack("R2", 16'h2002);
    rd(2'd3, rv); chk("R2 held no reset", rv, 0);
    wr(2'd2, '0);
    @(negedge clk); chk("R2 held no req", take_req, 0);
    irq_lines = '0;

    // R10 stray acknowledge
    wr(2'd0, '0);
    pulse(N'(1) << 8);
    saved = ret_addr;
    @(negedge clk); take_ack = 1'b1; pc_count = 16'hBEEF;
    @(negedge clk); take_ack = 1'b0;
    chk("R10 ret_addr", ret_addr, saved);
    chk("R10 gmask", gmask, 0);
    rd(2'd3, rv); chk("R10 flag", rv, N'(1) << 8);
    wr(2'd0, '1);
    @(negedge clk); chk("R10 cleanup", take_id, 9);
    ack("R10", 16'h0009);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule